// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between the serial bus controller of a byte-addressed non-volatile memory and its storage array. During a write transaction the controller hands it a start address and then each received data byte. The bytes are collected in a one-page buffer. Each byte position has a valid bit, so later only the bytes that actually arrived are written. The array is not touched while the bytes arrive. When the bus stop condition ends the transaction, the block samples the write-protect pin. If the pin is low and at least one byte is buffered, the commit starts.

During the commit the block raises `busy` for a fixed number of clock cycles, which models the self-timed programming time. While `busy` is high the controller withholds acknowledges, so a master can poll for completion. The valid bytes go to the array port one per cycle, in ascending page offset. Only the low address bits advance while bytes arrive. A long burst therefore wraps inside its page and overwrites earlier bytes; it never moves on to the next page.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset `busy` is 0 and `arr_we` is 0.
- R2: The k-th data byte of a transaction starting at address A is written to the address whose upper `ADDR_W-log2(PAGE_BYTES)` bits equal those of A and whose low bits equal (A + k) mod `PAGE_BYTES`.
- R3: When more than `PAGE_BYTES` bytes are sent, each page offset holds the last byte sent to it, and each offset is written once.
- R4: No array write occurs before the stop strobe of the transaction. `arr_we` is high only while `busy` is high.
- R5: If `wp_pin` is 1 in the cycle of the stop strobe, nothing is written and `busy` stays 0.
- R6: Changes of `wp_pin` after a commit has started do not change what is written or how long `busy` lasts.
- R7: A commit raises `busy` in the cycle after the stop strobe and holds it for exactly `WRITE_CYCLES` cycles.
- R8: A stop strobe with no data bytes since the last start strobe starts no commit: no write and no `busy`.
- R9: Only offsets that received a byte are written, each exactly once. Writes go in strictly ascending address order, one per cycle, and all fall inside the page.
- R10: Data and start strobes that arrive while `busy` is high have no effect.
- R11: A start strobe discards bytes buffered since the previous start when no stop came between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_stb | input | 1 | Word address received; opens a new write transaction |
| start_addr | input | ADDR_W | Starting byte address of the transaction |
| data_stb | input | 1 | One data byte received |
| data_in | input | 8 | Data byte value |
| stop_stb | input | 1 | Bus stop condition seen |
| wp_pin | input | 1 | Write-protect input, 1 = protected |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
A bad page-offset pointer or a missing wrap shows up as stored bytes at the wrong addresses, or as bytes that leak into a neighbouring page. The array image after the commit shows this within `WRITE_CYCLES` cycles of the stop. A stale or corrupted valid mask shows up as extra or missing array writes, or as a `busy` pulse after a stop with no data. Either one is seen at the ports within the first commit. A miscounted cycle counter shows up as a `busy` width that differs from `WRITE_CYCLES`, which the first commit reveals.

// File: rtl/page_commit_buffer.sv
`timescale 1ns/1ps
module page_commit_buffer #(
  parameter int ADDR_W       = 17,
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_stb,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              data_stb,
  input  logic [7:0]        data_in,
  input  logic              stop_stb,
  input  logic              wp_pin,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int HI_W  = ADDR_W - PG_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [PG_W-1:0] LAST_OFF = PG_W'(PAGE_BYTES - 1);

  logic [7:0]            page_buf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [HI_W-1:0]       page_hi;
  logic [PG_W-1:0]       wr_ptr;
  logic [PG_W-1:0]       scan_idx;
  logic                  scan_on;
  logic [CNT_W-1:0]      cyc_left;

  wire take_byte = !busy && !start_stb && data_stb;

  always_ff @(posedge clk)
    if (take_byte) page_buf[wr_ptr] <= data_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      valid    <= '0;
      page_hi  <= '0;
      wr_ptr   <= '0;
      scan_idx <= '0;
      scan_on  <= 1'b0;
      cyc_left <= '0;
    end else if (busy) begin
      if (scan_on) begin
        valid[scan_idx] <= 1'b0;
        scan_idx        <= scan_idx + 1'b1;
        if (scan_idx == LAST_OFF) scan_on <= 1'b0;
      end
      if (cyc_left == '0) busy <= 1'b0;
      else                cyc_left <= cyc_left - 1'b1;
    end else begin
      if (start_stb) begin
        page_hi <= start_addr[ADDR_W-1:PG_W];
        wr_ptr  <= start_addr[PG_W-1:0];
        valid   <= '0;
      end else if (data_stb) begin
        valid[wr_ptr] <= 1'b1;
        wr_ptr        <= wr_ptr + 1'b1;
      end
      if (stop_stb) begin
        if (|valid && !wp_pin) begin
          busy     <= 1'b1;
          scan_on  <= 1'b1;
          scan_idx <= '0;
          cyc_left <= CNT_W'(WRITE_CYCLES - 1);
        end else begin
          valid <= '0;
        end
      end
    end
  end

  assign arr_we    = busy && scan_on && valid[scan_idx];
  assign arr_addr  = {page_hi, scan_idx};
  assign arr_wdata = page_buf[scan_idx];
endmodule

module page_commit_buffer_chk #(
  parameter int ADDR_W       = 17,
  parameter int WRITE_CYCLES = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_stb,
  input logic              wp_pin,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int RW = $clog2(WRITE_CYCLES + 2);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk)
    if (!rst_n || !busy) run_cnt <= '0;
    else                 run_cnt <= run_cnt + 1'b1;

  // R4
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R5
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_stb) && !$past(wp_pin)));

  // R5
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && wp_pin && !busy) |=> !busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RW'(WRITE_CYCLES)));

  // R7
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < RW'(WRITE_CYCLES)));

  // R9
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr > $past(arr_addr)));
endmodule

bind page_commit_buffer page_commit_buffer_chk #(
  .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_stb(stop_stb), .wp_pin(wp_pin),
  .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/page_commit_buffer_test.sv
`timescale 1ns/1ps
module page_commit_buffer_test;
  localparam int AW = 10;
  localparam int P  = 16;
  localparam int W  = 40;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_stb = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic data_stb = 1'b0;
  logic [7:0] data_in = '0;
  logic stop_stb = 1'b0;
  logic wp_pin = 1'b0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  page_commit_buffer #(.ADDR_W(AW), .PAGE_BYTES(P), .WRITE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .start_addr(start_addr),
    .data_stb(data_stb), .data_in(data_in), .stop_stb(stop_stb), .wp_pin(wp_pin),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] got_mem [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];
  int wr_cnt = 0;
  int mon_err = 0;
  bit have_prev = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [AW-5:0] cur_hi = '0;

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      got_mem[arr_addr] = arr_wdata;
      wr_cnt++;
      if (!busy) mon_err++;
      if (have_prev && arr_addr <= prev_addr) mon_err++;
      if (arr_addr[AW-1:4] != cur_hi) mon_err++;
      prev_addr = arr_addr;
      have_prev = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int a = 0; a < MEMSZ; a++) if (got_mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  function automatic logic [7:0] dgen(input int addr, input int i, input int seed);
    return 8'((addr * 31 + i * 17 + seed * 7) & 255);
  endfunction

  task automatic pulse_start(input int addr);
    start_stb = 1'b1; start_addr = AW'(addr);
    @(negedge clk);
    start_stb = 1'b0;
    cur_hi = start_addr[AW-1:4];
  endtask

  task automatic send_byte(input logic [7:0] d);
    data_stb = 1'b1; data_in = d;
    @(negedge clk);
    data_stb = 1'b0;
  endtask

  task automatic finish_txn(input bit wp_val, input bit flip_wp, input bit junk,
                            input int exp_len, input int exp_wr, input string req);
    int n = 0;
    chk(wr_cnt == 0, "R4", wr_cnt, 0);
    wp_pin = wp_val; have_prev = 0; wr_cnt = 0; mon_err = 0;
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    while (busy && n < W + 10) begin
      n++;
      if (flip_wp) wp_pin = ~wp_pin;
      if (junk) begin data_stb = 1'b1; data_in = 8'hA5; end
      @(negedge clk);
      data_stb = 1'b0;
    end
    wp_pin = 1'b0;
    chk(n == exp_len, {req, "/R7 busy width"}, n, exp_len);
    chk(wr_cnt == exp_wr, {req, "/R9 write count"}, wr_cnt, exp_wr);
    chk(mon_err == 0, {req, "/R9 order"}, mon_err, 0);
    cmp_mem(req);
    wr_cnt = 0;
  endtask

  task automatic run_txn(input int addr, input int n, input bit wp_val, input bit flip_wp,
                         input bit junk, input int seed, input string req);
    int hi = addr / P;
    int off = addr % P;
    bit go = (n > 0) && !wp_val;
    wr_cnt = 0;
    pulse_start(addr);
    for (int i = 0; i < n; i++) send_byte(dgen(addr, i, seed));
    if (go)
      for (int i = 0; i < n; i++) exp_mem[hi * P + (off + i) % P] = dgen(addr, i, seed);
    finish_txn(wp_val, flip_wp, junk, go ? W : 0, go ? (n < P ? n : P) : 0, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens [9] = '{0, 1, 2, 7, 15, 16, 17, 20, 33};
    int pages [3] = '{0, 5, MEMSZ / P - 1};
    int seed = 1;
    for (int a = 0; a < MEMSZ; a++) begin got_mem[a] = 8'h00; exp_mem[a] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(arr_we == 1'b0, "R1 we", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && arr_we == 1'b0, "R1 idle", busy, 0);

    foreach (pages[p]) for (int off = 0; off < P; off++) foreach (lens[l]) begin
      seed++;
      run_txn(pages[p] * P + off, lens[l], 1'b0, 1'b0, 1'b0, seed,
              lens[l] == 0 ? "R8" : (lens[l] > P ? "R3" : "R2"));
    end

    run_txn(3 * P + 4, 9, 1'b1, 1'b0, 1'b0, 500, "R5");
    run_txn(3 * P + 4, 9, 1'b0, 1'b1, 1'b0, 501, "R6");
    run_txn(7 * P + 2, 5, 1'b0, 1'b0, 1'b1, 502, "R10");
    finish_txn(1'b0, 1'b0, 1'b0, 0, 0, "R10 empty after busy");

    wr_cnt = 0;
    pulse_start(9 * P + 1);
    for (int i = 0; i < 4; i++) send_byte(dgen(9 * P + 1, i, 600));
    pulse_start(9 * P + 12);
    for (int i = 0; i < 2; i++) begin
      send_byte(dgen(9 * P + 12, i, 601));
      exp_mem[9 * P + 12 + i] = dgen(9 * P + 12, i, 601);
    end
    finish_txn(1'b0, 1'b0, 1'b0, W, 2, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule